// File: doc/BRIEF.md
# HD-SDI Line Number and CRC Inserter

This block sits in the transmit path of an HD serial digital video link. It handles a pair of 10-bit streams, luma (Y) and chroma (C), and takes one word from each stream per enabled clock. Each stream is scanned on its own for timing reference words.

After an end-of-active-video reference, the two words that follow can be overwritten with an encoded 11-bit line number. The two words after those can be overwritten with an 18-bit CRC of that stream's line. Each insertion has its own enable. When the SD mode flag is high, every word passes through untouched.

Each word appears at the output one enabled clock after it is presented. When the clock enable is low, the block stalls: it takes nothing in and its outputs hold their values.

Top module: `hd_ln_crc_ins`

## Requirements
- R1: While rst_ni is low, both output streams read 000h.
- R2: When ce_i is high, the word presented is taken in, and its result appears on data_o after the next rising edge. When ce_i is low, data_o holds its value and the input word is ignored.
- R3: A stream's end reference is the input sequence 3FFh, 000h, 000h, XYZ with XYZ bit 6 = 1, counted over enabled words only. The four words after XYZ are LN0, LN1, CR0 and CR1, in that order. When XYZ bit 6 = 0 (a start reference), no word is replaced.
- R4: When ln_en_i = 1 and sd_mode_i = 0, LN0 becomes {~line[6], line[6:0], 00b}. This puts line bits 6..0 in word bits 8..2.
- R5: When ln_en_i = 1 and sd_mode_i = 0, LN1 becomes {1b, 000b, line[10:7], 00b}. This puts line bits 10..7 in word bits 5..2.
- R6: Each stream keeps an 18-bit CRC with the polynomial x^18+x^5+x^4+1. Each output word is shifted in bit 0 first. On every bit, f = crc[0]^d, then crc = (crc>>1) ^ (f ? 23000h : 0). The CRC is set to zero when a start reference XYZ arrives. It then covers every output word from the next word through LN1 inclusive.
- R7: When crc_en_i = 1 and sd_mode_i = 0, CR0 becomes {~crc[8], crc[8:0]} and CR1 becomes {~crc[17], crc[17:9]}.
- R8: When ln_en_i = 0, LN0 and LN1 pass unchanged. When crc_en_i = 0, CR0 and CR1 pass unchanged.
- R9: When sd_mode_i = 1, every word passes unchanged, whatever the enables are set to.
- R10: Y occupies data bits 9..0 and C occupies bits 19..10. Each stream has its own reference detection and its own CRC. Both streams take the same line_i value.
- R11: Every word that is not in an enabled LN or CR position passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for the data path |
| sd_mode_i | input | 1 | High selects SD mode, which bypasses both insertions |
| ln_en_i | input | 1 | Enables line number insertion |
| crc_en_i | input | 1 | Enables CRC insertion |
| line_i | input | 11 | Line number for the current line |
| data_i | input | 20 | Input words, C in bits 19..10 and Y in bits 9..0 |
| data_o | output | 20 | Output words, same layout as data_i |

## Verification
The hardest case to reach is a clock-enable gap that falls inside a reference sequence or inside the LN/CR window. In that case the ignored word must not disturb detection or CRC coverage. The bench drops ce_i on every third word of alternate lines and presents 3FFh/000h during the gap, so a design that shifts history on disabled cycles raises false references. The bench sweeps all eight combinations of the two enables and SD mode. Each combination runs over lines of varying length with line numbers that exercise the extremes of both line fields. Y and C carry different payloads, which gives them different CRCs.

// File: rtl/hd_ins_pkg.sv
package hd_ins_pkg;
  localparam int WORD_W = 10;
  localparam int LINE_W = 11;
  localparam int CRC_W  = 18;
  localparam int PRE_LEN = 3;
  localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [CRC_W-1:0]  crc_t;

  typedef enum logic [2:0] {
    POS_IDLE, POS_LN0, POS_LN1, POS_CR0, POS_CR1
  } pos_e;

  function automatic crc_t crc_step(input crc_t c, input word_t w);
    crc_t r;
    logic f;
    r = c;
    for (int b = 0; b < WORD_W; b++) begin
      f = r[0] ^ w[b];
      r = r >> 1;
      if (f) r = r ^ CRC_MASK;
    end
    return r;
  endfunction

  function automatic word_t enc_ln0(input line_t l);
    return {~l[6], l[6:0], 2'b00};
  endfunction

  function automatic word_t enc_ln1(input line_t l);
    return {1'b1, 3'b000, l[10:7], 2'b00};
  endfunction

  function automatic word_t enc_cr_lo(input crc_t c);
    return {~c[8], c[8:0]};
  endfunction

  function automatic word_t enc_cr_hi(input crc_t c);
    return {~c[17], c[17:9]};
  endfunction
endpackage

// File: rtl/hd_trs_find.sv
module hd_trs_find
  import hd_ins_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_i,
  input  word_t word_i,
  output logic  sav_o,
  output pos_e  pos_o
);
  localparam word_t ONES = {WORD_W{1'b1}};

  word_t hist_q [PRE_LEN];
  pos_e  pos_q;
  logic  pre;
  logic  eav;

  // hist_q[0] is the most recent enabled word
  assign pre   = (hist_q[PRE_LEN-1] == ONES) && (hist_q[1] == '0) && (hist_q[0] == '0);
  assign eav   = pre && word_i[6];
  assign sav_o = pre && !word_i[6];
  assign pos_o = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= '0;
      pos_q <= POS_IDLE;
    end else if (ce_i) begin
      hist_q[0] <= word_i;
      for (int i = 1; i < PRE_LEN; i++) hist_q[i] <= hist_q[i-1];
      if (eav) pos_q <= POS_LN0;
      else begin
        unique case (pos_q)
          POS_LN0: pos_q <= POS_LN1;
          POS_LN1: pos_q <= POS_CR0;
          POS_CR0: pos_q <= POS_CR1;
          default: pos_q <= POS_IDLE;
        endcase
      end
    end
  end

  // R3
  ln0_after_eav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && eav) |=> (pos_o == POS_LN0));
  // R3
  sav_no_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sav_o) |=> (pos_o == POS_IDLE));
  // R3
  slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !eav && pos_o == POS_LN1) |=> (pos_o == POS_CR0));
endmodule

// File: rtl/hd_crc_acc.sv
module hd_crc_acc
  import hd_ins_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_i,
  input  logic  clr_i,
  input  logic  last_i,
  input  word_t word_i,
  output crc_t  crc_o
);
  crc_t crc_q;
  logic in_line_q;

  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q     <= '0;
      in_line_q <= 1'b0;
    end else if (ce_i) begin
      if (clr_i) begin
        crc_q     <= '0;
        in_line_q <= 1'b1;
      end else if (in_line_q) begin
        crc_q <= crc_step(crc_q, word_i);
        if (last_i) in_line_q <= 1'b0;
      end
    end
  end

  // R6
  crc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && clr_i) |=> (crc_o == '0));
  // R6
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !clr_i && !in_line_q) |=> $stable(crc_o));
endmodule

// File: rtl/hd_stream_ins.sv
module hd_stream_ins
  import hd_ins_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_i,
  input  logic  sd_mode_i,
  input  logic  ln_en_i,
  input  logic  crc_en_i,
  input  line_t line_i,
  input  word_t word_i,
  output word_t word_o
);
  logic  sav;
  pos_e  pos;
  crc_t  crc;
  word_t nxt;
  word_t word_q;

  hd_trs_find u_trs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .word_i (word_i),
    .sav_o  (sav),
    .pos_o  (pos)
  );

  always_comb begin
    nxt = word_i;
    if (!sd_mode_i) begin
      unique case (pos)
        POS_LN0: if (ln_en_i)  nxt = enc_ln0(line_i);
        POS_LN1: if (ln_en_i)  nxt = enc_ln1(line_i);
        POS_CR0: if (crc_en_i) nxt = enc_cr_lo(crc);
        POS_CR1: if (crc_en_i) nxt = enc_cr_hi(crc);
        default: nxt = word_i;
      endcase
    end
  end

  // CRC runs over the post-insertion word so LN0/LN1 are covered as sent
  hd_crc_acc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .clr_i  (sav),
    .last_i (pos == POS_LN1),
    .word_i (nxt),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (ce_i) word_q <= nxt;
  end

  assign word_o = word_q;

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(word_o));
  // R9
  sd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sd_mode_i) |=> (word_o == $past(word_i)));
  // R8
  ln_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !ln_en_i && (pos == POS_LN0 || pos == POS_LN1)) |=> (word_o == $past(word_i)));
  // R4
  ln0_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && ln_en_i && !sd_mode_i && pos == POS_LN0) |=>
      (word_o[9] != word_o[8]) && (word_o[8:2] == $past(line_i[6:0])) && (word_o[1:0] == 2'b00));
  // R5
  ln1_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && ln_en_i && !sd_mode_i && pos == POS_LN1) |=>
      (word_o[9:6] == 4'b1000) && (word_o[5:2] == $past(line_i[10:7])) && (word_o[1:0] == 2'b00));
  // R7
  cr_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && crc_en_i && !sd_mode_i && (pos == POS_CR0 || pos == POS_CR1)) |=>
      (word_o[9] != word_o[8]));
endmodule

// File: rtl/hd_ln_crc_ins.sv
module hd_ln_crc_ins
  import hd_ins_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  localparam int DATA_W = NUM_STREAMS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sd_mode_i,
  input  logic              ln_en_i,
  input  logic              crc_en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    hd_stream_ins u_ins (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ce_i      (ce_i),
      .sd_mode_i (sd_mode_i),
      .ln_en_i   (ln_en_i),
      .crc_en_i  (crc_en_i),
      .line_i    (line_i),
      .word_i    (data_i[s*WORD_W +: WORD_W]),
      .word_o    (data_o[s*WORD_W +: WORD_W])
    );
  end

  // R1
  always_comb begin
    if (!rst_ni) reset_zero_chk: assert (data_o == '0);
  end
endmodule

// File: tb/tb_hd_ln_crc_ins.sv
`timescale 1ns/1ps
module tb_hd_ln_crc_ins;
  localparam int R_OTH = 0, R_SAV = 1, R_LN0 = 2, R_LN1 = 3, R_CR0 = 4, R_CR1 = 5, R_NEAR = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_i = 1'b0;
  logic        sd_mode_i = 1'b0;
  logic        ln_en_i = 1'b0;
  logic        crc_en_i = 1'b0;
  logic [10:0] line_i = '0;
  logic [19:0] data_i = '0;
  logic [19:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int gap_cnt = 0;
  logic [17:0] mcrc [2];
  bit          mact [2];
  logic [9:0]  last_exp [2];

  always #2.5 clk = ~clk;

  hd_ln_crc_ins dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .sd_mode_i(sd_mode_i),
    .ln_en_i(ln_en_i), .crc_en_i(crc_en_i), .line_i(line_i),
    .data_i(data_i), .data_o(data_o)
  );

  function automatic logic [17:0] m_crc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r;
    logic f;
    r = c;
    for (int b = 0; b < 10; b++) begin
      f = r[0] ^ w[b];
      r = r >> 1;
      if (f) r = r ^ 18'h23000;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] y, input logic [9:0] c, input int role, input bit en);
    logic [9:0] raw, e, act;
    int l, cv;
    string req;
    data_i = {c, y};
    ce_i = en;
    @(posedge clk);
    @(negedge clk);
    if (!en) begin
      check("R2 hold Y", data_o[9:0], last_exp[0]);
      check("R2 hold C", data_o[19:10], last_exp[1]);
    end else begin
      for (int s = 0; s < 2; s++) begin
        raw = s ? c : y;
        e = raw;
        l = int'(line_i);
        cv = int'(mcrc[s]);
        req = (role == R_NEAR) ? "R3 no slot after start" : "R11 pass";
        if (sd_mode_i) begin
          if (role >= R_LN0) req = "R9 sd bypass";
        end else begin
          case (role)
            R_LN0: if (ln_en_i) begin e = 10'((l % 128) * 4 + (((l / 64) % 2) ? 0 : 512)); req = "R4 ln0"; end
                   else req = "R8 ln off";
            R_LN1: if (ln_en_i) begin e = 10'(512 + (l / 128) * 4); req = "R5 ln1"; end
                   else req = "R8 ln off";
            R_CR0: if (crc_en_i) begin
                     e = 10'((cv % 512) + (((cv / 256) % 2) ? 0 : 512));
                     req = s ? "R10 C-stream cr0" : "R6 R7 cr0";
                   end else req = "R8 crc off";
            R_CR1: if (crc_en_i) begin
                     e = 10'((cv / 512) + (((cv / 131072) % 2) ? 0 : 512));
                     req = s ? "R10 C-stream cr1" : "R6 R7 cr1";
                   end else req = "R8 crc off";
            default: ;
          endcase
        end
        act = s ? data_o[19:10] : data_o[9:0];
        check(req, act, e);
        last_exp[s] = e;
        if (role == R_SAV) begin
          mcrc[s] = '0;
          mact[s] = 1'b1;
        end else if (mact[s]) begin
          mcrc[s] = m_crc(mcrc[s], e);
          if (role == R_LN1) mact[s] = 1'b0;
        end
      end
    end
  endtask

  task automatic put(input logic [9:0] y, input logic [9:0] c, input int role, input bit gap);
    if (gap && (gap_cnt % 3 == 2)) step(10'h3FF, 10'h000, R_OTH, 1'b0);
    gap_cnt++;
    step(y, c, role, 1'b1);
  endtask

  task automatic send_line(input int seed, input int nact, input bit gap);
    put(10'h3FF, 10'h3FF, R_OTH, gap);
    put(10'h000, 10'h000, R_OTH, gap);
    put(10'h000, 10'h000, R_OTH, gap);
    put(10'h200, 10'h200, R_SAV, gap);
    for (int k = 0; k < nact; k++)
      put(10'(2 + (k * 37 + seed * 11) % 1020), 10'(2 + (k * 53 + seed * 5 + 300) % 1020),
          (k < 2) ? R_NEAR : R_OTH, gap);
    put(10'h3FF, 10'h3FF, R_OTH, gap);
    put(10'h000, 10'h000, R_OTH, gap);
    put(10'h000, 10'h000, R_OTH, gap);
    put(10'h274, 10'h274, R_OTH, gap);
    put(10'h155, 10'h0AA, R_LN0, gap);
    put(10'h2AA, 10'h123, R_LN1, gap);
    put(10'h0CC, 10'h1F0, R_CR0, gap);
    put(10'h133, 10'h0F3, R_CR1, gap);
    for (int k = 0; k < 6; k++)
      put((k % 2) ? 10'h200 : 10'h040, (k % 2) ? 10'h040 : 10'h200, R_OTH, gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lines [6];
    lines = '{0, 2047, 1125, 64, 127, 1920};
    for (int s = 0; s < 2; s++) begin
      mcrc[s] = '0;
      mact[s] = 1'b0;
      last_exp[s] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset Y", data_o[9:0], 10'h000);
    check("R1 reset C", data_o[19:10], 10'h000);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      ln_en_i   = m[0];
      crc_en_i  = m[1];
      sd_mode_i = m[2];
      for (int i = 0; i < 6; i++) begin
        line_i = 11'(lines[i]);
        send_line(m * 7 + i, 4 + i * 3, i[0]);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule